// File: doc/BRIEF.md
# Transmit Data Descriptor Screen with Status Writeback

This block sits behind a descriptor fetch engine on a network transmit path. Extended transmit data descriptors arrive one per cycle, each a 128-bit word. The block decodes the command byte and rejects any descriptor whose kind it does not handle. For accepted descriptors it sums buffer byte counts across a packet. At the end-of-packet descriptor it applies two length rules: a minimum packet size, and a margin against the configured transmit FIFO size.

When a descriptor asks for status, the block emits a one-cycle writeback strobe carrying a status nibble with only the done bit set. It also produces the transmit interrupt. A status request without delay-enable raises the interrupt at once and cancels any pending delay. A status request with delay-enable starts a programmable countdown, but only if none is already running. The countdown keeps running across later descriptors and raises the interrupt when it expires.

Top module: `txdesc_screen`

## Requirements
- R1: `desc_ready` is always 1, so every cycle with `desc_valid` high accepts a descriptor. The descriptor is supported only when command bit 5 (word bit 93) is 1 and the kind field in word bits [87:84] equals 4'b0001. For any other descriptor, `err_kind` pulses in the cycle after acceptance and the descriptor has no other effect.
- R2: A supported descriptor with command bit 3 (status request, word bit 91) set makes `wb_valid` pulse in the cycle after acceptance, with `wb_status` equal to 4'b0001 (bit 0 is the done bit). Without that bit set there is no writeback.
- R3: A supported descriptor with the status request set and command bit 7 (delay enable, word bit 95) clear makes `irq` pulse in the same cycle as its writeback and cancels any running countdown.
- R4: A supported descriptor with both the status request and delay enable set, arriving while no countdown runs, makes `irq` pulse exactly D cycles after its writeback, where D is `delay_reload`. When D is 0, `irq` pulses together with the writeback.
- R5: A delayed status request that arrives while a countdown runs does not restart it. The interrupt still comes at the time set by the first request.
- R6: A descriptor without the status request leaves the countdown untouched and produces no interrupt.
- R7: `err_zero_len` is high in the same cycle as a valid supported descriptor whose byte count (word bits [83:64]) is 0.
- R8: When the byte counts of a packet's supported descriptors, up to and including the one with command bit 0 (last) set, add up to fewer than 17, `err_short` pulses in the cycle after the last descriptor is accepted.
- R9: When that packet sum plus 80 exceeds `fifo_bytes`, `err_fifo` pulses in the cycle after the last descriptor is accepted.
- R10: If any descriptor of a packet has command bit 2 (segmentation, word bit 90) set, neither `err_short` nor `err_fifo` is raised for that packet. The sum and the segmentation flag both restart after each last descriptor, and no length error is raised before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | Descriptor present |
| desc_ready | output | 1 | Always 1 |
| desc_word | input | 128 | Descriptor word |
| fifo_bytes | input | SUM_W | Configured transmit FIFO size in bytes |
| delay_reload | input | TMR_W | Countdown reload value in cycles |
| wb_valid | output | 1 | Status writeback strobe |
| wb_status | output | 4 | Status nibble written back |
| irq | output | 1 | Transmit interrupt pulse |
| err_kind | output | 1 | Unsupported descriptor pulse |
| err_zero_len | output | 1 | Zero byte count, same cycle |
| err_short | output | 1 | Packet below minimum length |
| err_fifo | output | 1 | Packet too large for FIFO margin |

## Verification
The assertions assume that `fifo_bytes` and `delay_reload` hold steady while a packet or a countdown is in progress. They also assume that a packet sum never reaches the saturation point of the accumulator. The stimulus changes those two inputs only between idle gaps long enough for any countdown to drain. It keeps every packet to a few hundred bytes. Interrupt timing is observed cycle by cycle against the reload value, including the cases where a second request overlaps a running countdown.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;

   localparam int unsigned WORD_W   = 128;
   localparam int unsigned NBYTES_W = 20;
   localparam logic [3:0]  KIND_DATA = 4'b0001;
   localparam logic [3:0]  STATUS_DONE = 4'b0001;

   // command byte, most significant bit first
   typedef struct packed {
      logic dly_en;
      logic tag_en;
      logic ext;
      logic spare;
      logic want_status;
      logic seg_en;
      logic add_fcs;
      logic last;
   } cmd_t;

   typedef struct packed {
      logic [15:0]         tag;
      logic [7:0]          opts;
      logic [3:0]          pad;
      logic [3:0]          stat;
      cmd_t                cmd;
      logic [3:0]          kind;
      logic [NBYTES_W-1:0] nbytes;
      logic [63:0]         buf_addr;
   } desc_t;

endpackage

// File: rtl/txdesc_decode.sv
module txdesc_decode
   import txdesc_pkg::*;
(
   input  logic [WORD_W-1:0]   word_i,
   output logic                ok_o,
   output cmd_t                cmd_o,
   output logic [NBYTES_W-1:0] nbytes_o,
   output logic                zero_o
);
   desc_t d;

   always_comb begin
      d        = desc_t'(word_i);
      cmd_o    = d.cmd;
      nbytes_o = d.nbytes;
      ok_o     = d.cmd.ext && (d.kind == KIND_DATA);
      zero_o   = (d.nbytes == '0);
   end
endmodule

// File: rtl/txdesc_len_acc.sv
module txdesc_len_acc
   import txdesc_pkg::*;
#(
   parameter int unsigned SUM_W       = 24,
   parameter bit          SUM_SAT     = 1'b1,
   parameter int unsigned MIN_PKT     = 17,
   parameter int unsigned FIFO_MARGIN = 80
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take_i,
   input  logic [NBYTES_W-1:0] nbytes_i,
   input  logic                last_i,
   input  logic                seg_i,
   input  logic [SUM_W-1:0]    fifo_bytes_i,
   output logic                err_short_o,
   output logic                err_fifo_o
);
   localparam int unsigned EXT_W = SUM_W - NBYTES_W;

   if (SUM_W <= NBYTES_W) begin : g_bad_width
      $error("txdesc_len_acc: SUM_W must exceed the byte count width");
   end
   if (MIN_PKT == 0) begin : g_bad_min
      $error("txdesc_len_acc: MIN_PKT must be nonzero");
   end

   logic [SUM_W-1:0] sum_q;
   logic             seg_q;
   logic [SUM_W-1:0] sum_nx;
   logic [SUM_W:0]   wide;
   logic             seg_nx;

   assign wide   = {1'b0, sum_q} + {1'b0, {EXT_W{1'b0}}, nbytes_i};
   assign seg_nx = seg_q | seg_i;

   if (SUM_SAT) begin : g_sat
      assign sum_nx = wide[SUM_W] ? {SUM_W{1'b1}} : wide[SUM_W-1:0];
   end else begin : g_wrap
      assign sum_nx = wide[SUM_W-1:0];
   end

   logic short_hit, fifo_hit;
   assign short_hit = !seg_nx && (sum_nx < SUM_W'(MIN_PKT));
   assign fifo_hit  = !seg_nx &&
                      (({1'b0, sum_nx} + (SUM_W+1)'(FIFO_MARGIN)) > {1'b0, fifo_bytes_i});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q       <= '0;
         seg_q       <= 1'b0;
         err_short_o <= 1'b0;
         err_fifo_o  <= 1'b0;
      end else begin
         err_short_o <= 1'b0;
         err_fifo_o  <= 1'b0;
         if (take_i) begin
            if (last_i) begin
               sum_q       <= '0;
               seg_q       <= 1'b0;
               err_short_o <= short_hit;
               err_fifo_o  <= fifo_hit;
            end else begin
               sum_q <= sum_nx;
               seg_q <= seg_nx;
            end
         end
      end
   end

   // R8 R9
   length_err_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_short_o || err_fifo_o) |-> $past(take_i && last_i));

   // R10
   sum_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && last_i) |=> (sum_q == '0 && !seg_q));

   // R10
   seg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && last_i && seg_i) |=> (!err_short_o && !err_fifo_o));
endmodule

// File: rtl/txdesc_irq_timer.sv
module txdesc_irq_timer #(
   parameter int unsigned TMR_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_now_i,
   input  logic             arm_i,
   input  logic [TMR_W-1:0] reload_i,
   output logic             irq_o
);
   if (TMR_W < 1 || TMR_W > 32) begin : g_bad_tmr
      $error("txdesc_irq_timer: TMR_W out of range");
   end

   logic [TMR_W-1:0] cnt_q;
   logic             busy;
   assign busy = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_o <= 1'b0;
      end else if (fire_now_i) begin
         cnt_q <= '0;
         irq_o <= 1'b1;
      end else if (arm_i && !busy) begin
         if (reload_i == '0) begin
            irq_o <= 1'b1;
         end else begin
            cnt_q <= reload_i;
            irq_o <= 1'b0;
         end
      end else if (busy) begin
         cnt_q <= cnt_q - 1'b1;
         irq_o <= (cnt_q == TMR_W'(1));
      end else begin
         irq_o <= 1'b0;
      end
   end

   // R3
   fire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_now_i |=> (irq_o && cnt_q == '0));

   // R5
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fire_now_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !fire_now_i && !arm_i) |=> (!irq_o && cnt_q == '0));
endmodule

// File: rtl/txdesc_screen.sv
module txdesc_screen
   import txdesc_pkg::*;
#(
   parameter int unsigned SUM_W       = 24,
   parameter int unsigned TMR_W       = 16,
   parameter bit          SUM_SAT     = 1'b1,
   parameter int unsigned MIN_PKT     = 17,
   parameter int unsigned FIFO_MARGIN = 80
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desc_valid,
   output logic              desc_ready,
   input  logic [127:0]      desc_word,
   input  logic [SUM_W-1:0]  fifo_bytes,
   input  logic [TMR_W-1:0]  delay_reload,
   output logic              wb_valid,
   output logic [3:0]        wb_status,
   output logic              irq,
   output logic              err_kind,
   output logic              err_zero_len,
   output logic              err_short,
   output logic              err_fifo
);
   if (WORD_W != 128) begin : g_bad_word
      $error("txdesc_screen: descriptor word must be 128 bits");
   end

   logic                dec_ok;
   cmd_t                dec_cmd;
   logic [NBYTES_W-1:0] dec_nbytes;
   logic                dec_zero;
   logic                take;

   txdesc_decode u_decode (
      .word_i   (desc_word),
      .ok_o     (dec_ok),
      .cmd_o    (dec_cmd),
      .nbytes_o (dec_nbytes),
      .zero_o   (dec_zero)
   );

   assign desc_ready   = 1'b1;
   assign take         = desc_valid && dec_ok;
   assign err_zero_len = take && dec_zero;

   txdesc_len_acc #(
      .SUM_W       (SUM_W),
      .SUM_SAT     (SUM_SAT),
      .MIN_PKT     (MIN_PKT),
      .FIFO_MARGIN (FIFO_MARGIN)
   ) u_len (
      .clk          (clk),
      .rst_n        (rst_n),
      .take_i       (take),
      .nbytes_i     (dec_nbytes),
      .last_i       (dec_cmd.last),
      .seg_i        (dec_cmd.seg_en),
      .fifo_bytes_i (fifo_bytes),
      .err_short_o  (err_short),
      .err_fifo_o   (err_fifo)
   );

   txdesc_irq_timer #(.TMR_W(TMR_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_now_i (take && dec_cmd.want_status && !dec_cmd.dly_en),
      .arm_i      (take && dec_cmd.want_status && dec_cmd.dly_en),
      .reload_i   (delay_reload),
      .irq_o      (irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_valid  <= 1'b0;
         wb_status <= '0;
         err_kind  <= 1'b0;
      end else begin
         wb_valid  <= take && dec_cmd.want_status;
         wb_status <= (take && dec_cmd.want_status) ? STATUS_DONE : 4'b0000;
         err_kind  <= desc_valid && !dec_ok;
      end
   end

   // R2
   wb_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> ($past(desc_valid) && $past(desc_word[91]) && $past(desc_word[93])));

   // R1
   kind_err_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_kind |-> !wb_valid);

   // R7
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_zero_len |-> (desc_valid && desc_word[83:64] == 20'd0));
endmodule

// File: tb/txdesc_screen_bench.sv
module txdesc_screen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SUM_W = 24;
   localparam int TMR_W = 16;

   localparam logic [7:0] C_LAST = 8'h01;
   localparam logic [7:0] C_SEG  = 8'h04;
   localparam logic [7:0] C_REQ  = 8'h08;
   localparam logic [7:0] C_EXT  = 8'h20;
   localparam logic [7:0] C_TAG  = 8'h40;
   localparam logic [7:0] C_DLY  = 8'h80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic desc_valid = 1'b0;
   logic desc_ready;
   logic [127:0] desc_word = '0;
   logic [SUM_W-1:0] fifo_bytes = SUM_W'(1000);
   logic [TMR_W-1:0] delay_reload = '0;
   logic wb_valid, irq, err_kind, err_zero_len, err_short, err_fifo;
   logic [3:0] wb_status;

   int total = 0;
   int bad = 0;
   int seq = 0;
   logic s_wb, s_irq, s_kind, s_zero, s_short, s_fifo, s_rdy;
   logic [3:0] s_st;

   always #(CLK_PERIOD/2) clk = ~clk;

   txdesc_screen u_txdesc_screen (
      .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_word(desc_word), .fifo_bytes(fifo_bytes), .delay_reload(delay_reload),
      .wb_valid(wb_valid), .wb_status(wb_status), .irq(irq), .err_kind(err_kind),
      .err_zero_len(err_zero_len), .err_short(err_short), .err_fifo(err_fifo)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [127:0] mk(input logic [19:0] n, input logic [3:0] k,
                                       input logic [7:0] c, input int s);
      return {16'(s * 7 + 3), 8'hA5, 4'h0, 4'h6, c, k, n, 64'(s) * 64'h1_0001_0001};
   endfunction

   task automatic send(input logic [19:0] n, input logic [3:0] k, input logic [7:0] c);
      seq++;
      desc_word  = mk(n, k, c, seq);
      desc_valid = 1'b1;
      #1;
      s_zero = err_zero_len;
      s_rdy  = desc_ready;
      @(negedge clk);
      desc_valid = 1'b0;
      s_wb = wb_valid; s_st = wb_status; s_irq = irq;
      s_kind = err_kind; s_short = err_short; s_fifo = err_fifo;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      chk("R2 reset wb_valid", int'(wb_valid), 0);
      chk("R4 reset irq", int'(irq), 0);
      chk("R1 reset err_kind", int'(err_kind), 0);
      rst_n = 1'b1;
      idle(2);

      // R1 R2 R3: sweep extension bit and kind field
      for (int x = 0; x < 2; x++) begin
         for (int k = 0; k < 16; k++) begin
            logic sup;
            sup = (x == 1) && (k == 1);
            send(20'd100, 4'(k), C_REQ | C_LAST | (x == 1 ? C_EXT : 8'h00));
            chk("R1 desc_ready", int'(s_rdy), 1);
            chk("R1 err_kind", int'(s_kind), int'(!sup));
            chk("R2 wb_valid", int'(s_wb), int'(sup));
            chk("R2 wb_status", int'(s_st), sup ? 1 : 0);
            chk("R3 irq immediate", int'(s_irq), int'(sup));
         end
      end

      // R8: single-descriptor packets around the minimum
      for (int n = 1; n <= 20; n++) begin
         send(20'(n), 4'd1, C_EXT | C_LAST | C_TAG);
         chk("R8 err_short single", int'(s_short), int'(n < 17));
         chk("R9 err_fifo quiet", int'(s_fifo), 0);
         chk("R2 no wb without request", int'(s_wb), 0);
      end

      // R8 R10: two-descriptor packets
      for (int a = 1; a <= 9; a++) begin
         for (int b = 1; b <= 9; b++) begin
            send(20'(a), 4'd1, C_EXT);
            chk("R10 no error before last", int'(s_short), 0);
            send(20'(b), 4'd1, C_EXT | C_LAST);
            chk("R8 err_short pair", int'(s_short), int'(a + b < 17));
         end
      end

      // R10: segmentation suppresses checks and clears after last
      for (int n = 1; n <= 5; n++) begin
         send(20'(n), 4'd1, C_EXT | C_LAST | C_SEG);
         chk("R10 seg no short", int'(s_short), 0);
      end
      send(20'd3, 4'd1, C_EXT | C_SEG);
      send(20'd4, 4'd1, C_EXT | C_LAST);
      chk("R10 seg earlier desc", int'(s_short), 0);
      send(20'd5, 4'd1, C_EXT | C_LAST);
      chk("R10 seg flag restarts", int'(s_short), 1);
      // unsupported descriptor adds nothing
      send(20'd50, 4'd3, C_EXT);
      send(20'd10, 4'd1, C_EXT | C_LAST);
      chk("R1 unsupported not summed", int'(s_short), 1);

      // R9: FIFO margin sweep
      fifo_bytes = SUM_W'(200);
      idle(1);
      for (int n = 110; n <= 130; n++) begin
         send(20'(n), 4'd1, C_EXT | C_LAST);
         chk("R9 err_fifo", int'(s_fifo), int'(n + 80 > 200));
      end
      send(20'd60, 4'd1, C_EXT);
      send(20'd70, 4'd1, C_EXT | C_LAST);
      chk("R9 err_fifo pair", int'(s_fifo), 1);
      send(20'd150, 4'd1, C_EXT | C_LAST | C_SEG);
      chk("R10 seg no fifo err", int'(s_fifo), 0);
      fifo_bytes = SUM_W'(1000);

      // R7: zero byte count
      send(20'd0, 4'd1, C_EXT);
      chk("R7 zero supported", int'(s_zero), 1);
      send(20'd0, 4'd2, C_EXT);
      chk("R7 zero unsupported", int'(s_zero), 0);
      send(20'd30, 4'd1, C_EXT | C_LAST);
      chk("R7 nonzero", int'(s_zero), 0);

      // R6: no request leaves timer idle
      delay_reload = 16'd3;
      send(20'd30, 4'd1, C_EXT | C_DLY | C_LAST);
      chk("R6 irq idx0", int'(s_irq), 0);
      for (int i = 1; i <= 6; i++) begin
         @(negedge clk);
         chk("R6 irq stays low", int'(irq), 0);
      end

      // R4: delay sweep
      for (int d = 0; d <= 6; d++) begin
         delay_reload = 16'(d);
         idle(1);
         send(20'd30, 4'd1, C_EXT | C_REQ | C_DLY | C_LAST);
         chk("R4 wb with delay", int'(s_wb), 1);
         chk("R4 irq idx0", int'(s_irq), int'(d == 0));
         for (int i = 1; i <= d + 3; i++) begin
            @(negedge clk);
            chk("R4 irq timing", int'(irq), int'(i == d));
         end
      end

      // R5: second delayed request while counting
      delay_reload = 16'd6;
      idle(2);
      send(20'd30, 4'd1, C_EXT | C_REQ | C_DLY | C_LAST);
      @(negedge clk);
      chk("R5 irq idx1", int'(irq), 0);
      send(20'd30, 4'd1, C_EXT | C_REQ | C_DLY | C_LAST);
      chk("R5 irq idx2", int'(s_irq), 0);
      for (int i = 3; i <= 12; i++) begin
         @(negedge clk);
         chk("R5 irq from first request", int'(irq), int'(i == 6));
      end

      // R3: immediate request cancels countdown
      idle(2);
      send(20'd30, 4'd1, C_EXT | C_REQ | C_DLY | C_LAST);
      @(negedge clk);
      send(20'd30, 4'd1, C_EXT | C_REQ | C_LAST);
      chk("R3 irq immediate", int'(s_irq), 1);
      for (int i = 3; i <= 12; i++) begin
         @(negedge clk);
         chk("R3 countdown cleared", int'(irq), 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule